// File: doc/BRIEF.md
# Serial Register Access Interface

This block is the slave side of a serial port that gives a host access to a data converter's register bank. The host holds an active-low frame-sync input low and toggles a serial clock while it exchanges one 16-bit word in each direction, most significant bit first. The word the host sends is a write command. Its top two bits select the target register and its low 14 bits are the payload. The word the block sends back comes from the register named by a read-select field. That field lives in the control register, which the host can write but never read back.

The register bank holds a control register, a test register and a small array of calibration registers. The array is addressed by an index field inside the control register. It also holds a conversion-data register, loaded by the converter core with each 12-bit result. The status word is a live input from the core and is captured when a frame starts. A write takes effect only when a frame has delivered all 16 bits. Short frames are thrown away and extra bits are ignored.

The serial pins are sampled by the block's core clock, which must run several times faster than the serial clock. The pins are assumed to arrive already synchronous to that core clock. The output pin's tri-state driver is controlled by a separate output-enable port.

Top module: `sra_port`

## Requirements
- R1: While `fs_n` is low, `sdi` is sampled at each rising edge of `sclk`, most significant bit first. Bits 15:14 of the received word are the write address and bits 13:0 are the payload.
- R2: Write address 2'b11 loads the payload into the control register, which is visible on `ctrl_out`.
- R3: Write address 2'b01 loads the payload into the test register. With read-select 2'b01, a read returns {2'b00, test}.
- R4: Write address 2'b10 loads the payload into the calibration register chosen by control bits 1:0. With read-select 2'b10, a read returns {2'b00, cal[control bits 1:0]}.
- R5: Write address 2'b00 changes no register.
- R6: A register is updated only after the 16th rising `sclk` edge of a frame. A frame in which `fs_n` returns high after fewer than 16 edges changes nothing.
- R7: Control bits 7:6 form the read-select field: 2'b00 selects conversion data, 2'b01 test, 2'b10 calibration and 2'b11 status. The field resets to 2'b00. The returned word is captured when `fs_n` falls, so a new selection applies from the next frame and stays in force until it is rewritten.
- R8: A conversion-data read returns four zero bits followed by the 12-bit result last loaded with `conv_load`.
- R9: A status read returns `status_in` as captured when the frame starts. Neither the status word nor the conversion data can be changed through the serial port.
- R10: The bit being returned moves to `sdo` after each falling `sclk` edge, and the MSB is on `sdo` before the first rising edge. `sdo_oe` is high only while a frame is active, and `sdo` is 0 whenever `sdo_oe` is low.
- R11: Serial clock edges after the 16th in a frame are ignored, and a frame commits at most once.
- R12: Reset clears the control, test, calibration and conversion-data registers and leaves the output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_n | input | 1 | Active-low frame sync |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| conv_load | input | 1 | Loads `conv_result` into the conversion-data register |
| conv_result | input | DATA_W (12) | Conversion result from the core |
| status_in | input | 16 | Live status word from the core |
| ctrl_out | output | 14 | Current control register contents |

## Verification
The main stimulus is a chain of full 16-bit frames. Each frame writes one address and reads back whatever the previous frames selected, so one pass shows the address decode, the one-frame lag of a new read selection, and the persistence of that selection. The payloads use alternating bit patterns (2AAA, 1555) and distinct calibration indices, which separate bit-order faults and index faults from decode faults. Directed frames then cut a frame short at 10 and at 15 bits, and stretch one to 20 bits. These show that only a complete word commits and that excess clocks do not shift the payload. A mid-run reset shows that every register is cleared.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int RSEL_LSB = 6;
  localparam int CIDX_LSB = 0;

  typedef enum logic [ADDR_W-1:0] {
    WA_NONE = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } wr_addr_e;

  typedef enum logic [1:0] {
    RS_DATA = 2'b00,
    RS_TEST = 2'b01,
    RS_CAL  = 2'b10,
    RS_STAT = 2'b11
  } rd_sel_e;
endpackage

// File: rtl/sra_shifter.sv
module sra_shifter
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q, fsn_q, commit_q, commit_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sin_q, sin_d, sout_q, sout_d;
  logic              start, rise, fall;

  assign start = fsn_q & ~fs_n;
  assign rise  = ~fs_n & ~start & sclk & ~sclk_q;
  assign fall  = ~fs_n & ~start & ~sclk & sclk_q;

  always_comb begin
    cnt_d    = cnt_q;
    sin_d    = sin_q;
    sout_d   = sout_q;
    commit_d = 1'b0;
    if (fs_n) begin
      cnt_d = '0;
    end else if (start) begin
      cnt_d  = '0;
      sout_d = rd_word_i;
    end else begin
      if (rise && (cnt_q < FULL)) begin
        sin_d    = {sin_q[WORD_W-2:0], sdi};
        cnt_d    = cnt_q + 1'b1;
        commit_d = (cnt_q == LAST);
      end
      if (fall) begin
        sout_d = {sout_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      fsn_q    <= 1'b1;
      cnt_q    <= '0;
      sin_q    <= '0;
      sout_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      fsn_q    <= fs_n;
      cnt_q    <= cnt_d;
      sin_q    <= sin_d;
      sout_q   <= sout_d;
      commit_q <= commit_d;
    end
  end

  assign sdo_oe   = ~fsn_q;
  assign sdo      = sout_q[WORD_W-1] & ~fsn_q;
  assign commit_o = commit_q;
  assign word_o   = sin_q;

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R6
  commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (cnt_q == FULL));
endmodule

// File: rtl/sra_regbank.sv
module sra_regbank
  import sra_pkg::*;
#(
  parameter int NCAL   = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              conv_load_i,
  input  logic [DATA_W-1:0] conv_result_i,
  output logic [PAY_W-1:0]  ctrl_o,
  output logic [PAY_W-1:0]  test_o,
  output logic [PAY_W-1:0]  cal_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CIDX_W = (NCAL > 1) ? $clog2(NCAL) : 1;

  wr_addr_e          waddr;
  logic [PAY_W-1:0]  payload;
  logic              ctrl_we, test_we, cal_we;
  logic [CIDX_W-1:0] cidx;
  logic [PAY_W-1:0]  ctrl_q, ctrl_d, test_q, test_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [PAY_W-1:0]  cal_q [NCAL];

  assign waddr   = wr_addr_e'(word_i[WORD_W-1 -: ADDR_W]);
  assign payload = word_i[PAY_W-1:0];
  assign ctrl_we = commit_i && (waddr == WA_CTRL);
  assign test_we = commit_i && (waddr == WA_TEST);
  assign cal_we  = commit_i && (waddr == WA_CAL);
  assign cidx    = ctrl_q[CIDX_LSB +: CIDX_W];

  always_comb begin
    ctrl_d = ctrl_we ? payload : ctrl_q;
    test_d = test_we ? payload : test_q;
    data_d = conv_load_i ? conv_result_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      test_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      test_q <= test_d;
      data_q <= data_d;
    end
  end

  for (genvar g = 0; g < NCAL; g++) begin : g_cal
    logic en;
    assign en = cal_we && (cidx == CIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cal_q[g] <= '0;
      else if (en) cal_q[g] <= payload;
    end
  end

  assign ctrl_o = ctrl_q;
  assign test_o = test_q;
  assign cal_o  = cal_q[cidx];
  assign data_o = data_q;

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_i) |-> ($stable(ctrl_q) && $stable(test_q)));

  // R5
  null_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit_i) && ($past(word_i[WORD_W-1 -: ADDR_W]) == 2'b00))
      |-> ($stable(ctrl_q) && $stable(test_q) && $stable(cal_o)));

  // R9
  data_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_load_i) |-> $stable(data_q));
endmodule

// File: rtl/sra_readmux.sv
module sra_readmux
  import sra_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  rd_sel_e           sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAY_W-1:0]  test_i,
  input  logic [PAY_W-1:0]  cal_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int DPAD = WORD_W - DATA_W;

  always_comb begin
    unique case (sel_i)
      RS_DATA: word_o = {{DPAD{1'b0}}, data_i};
      RS_TEST: word_o = {{ADDR_W{1'b0}}, test_i};
      RS_CAL:  word_o = {{ADDR_W{1'b0}}, cal_i};
      default: word_o = stat_i;
    endcase
  end
endmodule

// File: rtl/sra_port.sv
module sra_port
  import sra_pkg::*;
#(
  parameter int NCAL   = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              conv_load,
  input  logic [DATA_W-1:0] conv_result,
  input  logic [WORD_W-1:0] status_in,
  output logic [PAY_W-1:0]  ctrl_out
);
  logic              rst_meta, rst_i;
  logic              commit;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [PAY_W-1:0]  test_v, cal_v;
  logic [DATA_W-1:0] data_v;
  rd_sel_e           rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  sra_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_i),
    .fs_n      (fs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .rd_word_i (rd_word),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .commit_o  (commit),
    .word_o    (wr_word)
  );

  sra_regbank #(.NCAL(NCAL), .DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_i),
    .commit_i      (commit),
    .word_i        (wr_word),
    .conv_load_i   (conv_load),
    .conv_result_i (conv_result),
    .ctrl_o        (ctrl_out),
    .test_o        (test_v),
    .cal_o         (cal_v),
    .data_o        (data_v)
  );

  assign rsel = rd_sel_e'(ctrl_out[RSEL_LSB +: 2]);

  sra_readmux #(.DATA_W(DATA_W)) u_mux (
    .sel_i  (rsel),
    .data_i (data_v),
    .test_i (test_v),
    .cal_i  (cal_v),
    .stat_i (status_in),
    .word_o (rd_word)
  );

  // R8
  data_lead_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rsel == RS_DATA) |-> (rd_word[WORD_W-1:DATA_W] == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    fs_n |=> !sdo);
endmodule

// File: tb/tb_sra_port.sv
module tb_sra_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        conv_load = 1'b0;
  logic [11:0] conv_result = '0;
  logic [15:0] status_in = '0;
  logic        sdo, sdo_oe;
  logic [13:0] ctrl_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sra_port dut (
    .clk(clk), .rst_n(rst_n), .fs_n(fs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_load(conv_load),
    .conv_result(conv_result), .status_in(status_in), .ctrl_out(ctrl_out)
  );

  typedef struct packed {
    logic [15:0] wr;
    logic [15:0] rd;
    logic [13:0] ctl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h5234, 16'h0ABC, 14'h0000},  // R3 write test, R7 default select, R8
    '{16'hC040, 16'h0ABC, 14'h0040},  // R2 select test, R7 lag of one frame
    '{16'h3FFF, 16'h1234, 14'h0040},  // R5 null address, R3 readback
    '{16'hC081, 16'h1234, 14'h0081},  // R7 persistence, R5 test unchanged
    '{16'hAAAA, 16'h0000, 14'h0081},  // R4 write cal index 1
    '{16'hC080, 16'h2AAA, 14'h0080},  // R4 read cal index 1
    '{16'h9555, 16'h0000, 14'h0080},  // R4 write cal index 0
    '{16'hC0C0, 16'h1555, 14'h00C0},  // R4 read cal index 0, R1 bit order
    '{16'h0000, 16'h5A3C, 14'h00C0},  // R9 status read
    '{16'hC000, 16'h5A3C, 14'h0000},  // R9 R7 select back to data
    '{16'h0001, 16'h0ABC, 14'h0000}   // R8 R10 data read
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] rd);
    rd = '0;
    fs_n = 1'b0;
    tick(3);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      tick(2);
      if (i < 16) rd[15-i] = sdo;
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
      tick(3);
    end
    fs_n = 1'b1;
    tick(3);
  endtask

  initial begin
    logic [15:0] rd;
    tick(3);
    // R12 state while reset is held
    check("R12 ctrl in reset", {2'b00, ctrl_out}, 16'h0000);
    check("R12 oe in reset", {15'd0, sdo_oe}, 16'h0000);
    rst_n = 1'b1;
    tick(4);
    check("R10 sdo idle", {15'd0, sdo}, 16'h0000);

    status_in   = 16'h5A3C;
    conv_result = 12'hABC;
    conv_load   = 1'b1;
    tick(1);
    conv_load   = 1'b0;
    tick(2);

    for (int v = 0; v < NV; v++) begin
      xfer(VECS[v].wr, 16, rd);
      check($sformatf("R1 R7 readback vec %0d", v), rd, VECS[v].rd);
      check($sformatf("R2 R5 ctrl vec %0d", v), {2'b00, ctrl_out}, {2'b00, VECS[v].ctl});
    end

    // R6 short control frame changes nothing
    xfer(16'hC040, 10, rd);
    check("R6 ctrl after 10-bit frame", {2'b00, ctrl_out}, 16'h0000);
    // R6 short test frame (15 bits)
    xfer(16'h4FFF, 15, rd);
    // R11 20-bit frame commits the first 16 bits only
    xfer(16'hC040, 20, rd);
    check("R11 ctrl after 20-bit frame", {2'b00, ctrl_out}, 16'h0040);
    xfer(16'h0000, 16, rd);
    check("R6 test kept after 15-bit frame", rd, 16'h1234);

    // R8 new conversion result
    conv_result = 12'h123;
    conv_load   = 1'b1;
    tick(1);
    conv_load   = 1'b0;
    tick(2);
    xfer(16'hC000, 16, rd);
    check("R7 test still selected", rd, 16'h1234);
    xfer(16'h0000, 16, rd);
    check("R8 new result with leading zeros", rd, 16'h0123);

    // R10 output enable tracks the frame
    fs_n = 1'b0;
    tick(3);
    check("R10 oe in frame", {15'd0, sdo_oe}, 16'h0001);
    fs_n = 1'b1;
    tick(3);
    check("R10 oe after frame", {15'd0, sdo_oe}, 16'h0000);
    check("R10 sdo after frame", {15'd0, sdo}, 16'h0000);

    // R12 reset in mid-run clears all storage
    xfer(16'hC0C0, 16, rd);
    rst_n = 1'b0;
    tick(2);
    check("R12 ctrl after reset", {2'b00, ctrl_out}, 16'h0000);
    rst_n = 1'b1;
    tick(4);
    xfer(16'h0000, 16, rd);
    check("R12 data cleared", rd, 16'h0000);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule